// File: doc/BRIEF.md
# Timed Power Rail Sequencer

This controller brings five groups of supply rails up in a set order and takes them down in the opposite order. A power-on request in standby starts a millisecond count. Each group has its own 6-bit delay, and its enable turns on once the count reaches that delay. Group 0 drives the pair of linear regulators. Groups 1 to 3 drive the three buck converters. Group 4 releases the system reset.

At power-down each group stays on until the count reaches 63 minus its own power-on delay. So the last group to turn on is the first to turn off. The request input should also be pulsed when a battery is attached, so battery attach starts the same power-on sequence.

Once power-up has started, the host must confirm it within 128 ms. Either the acknowledge pin or the register acknowledge bit counts. If neither arrives, the block powers down on its own. The delays are captured when power-up starts and are kept until the block is back in standby. Timing advances only on a single-cycle 1 ms tick.

Top module: `pwr_rail_seq`

## Requirements
- R1: After reset, and whenever the block is in standby, all five enables, `busy` and `active` are 0.
- R2: A `pwr_on_req` pulse in standby starts power-up. From the next cycle `busy` is 1, the millisecond count restarts at 0, and the delay fields are captured. Field i of `dly_cfg` is bits [6i+5:6i], and group i drives `rail_en[i]`.
- R3: During power-up, `rail_en[i]` turns on in the cycle after the tick that brings the count to delay i. A delay of 0 turns the enable on at once. Once on, an enable stays on.
- R4: After 63 ticks of power-up the block goes to the active state: `active` is 1, `busy` is 0 and all enables are 1.
- R5: `pwr_off_req` in the active state starts power-down and restarts the count at 0. `rail_en[i]` stays on while the count is below 63 minus delay i, and does not turn on again. After 63 ticks the block returns to standby.
- R6: A high level on `ack_pin` or on `ack_reg_bit` at any time during power-up or the active state acknowledges the power-on, and the block stays active with no time limit.
- R7: If no acknowledgement has arrived, the 128th tick after the start puts the block into power-down, as if `pwr_off_req` had been given.
- R8: `pwr_on_req` outside standby has no effect. This includes a request during power-down.
- R9: Changes to `dly_cfg` after power-up has started have no effect on the enables until the next start.
- R10: `pwr_off_req` is ignored during power-up and in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | Single-cycle pulse once per millisecond |
| pwr_on_req | input | 1 | Power-on request (button event or battery attach) |
| ack_pin | input | 1 | Acknowledge pin from the host |
| ack_reg_bit | input | 1 | Acknowledge bit from the host register |
| pwr_off_req | input | 1 | Power-off request |
| dly_cfg | input | 30 | Five 6-bit power-on delays in ms; field i is bits [6i+5:6i] |
| rail_en | output | 5 | Group enables; bit 0 is the linear pair, bit 4 the reset release |
| busy | output | 1 | Power-up or power-down in progress |
| active | output | 1 | All groups on, sequence complete |

## Verification
The hardest case to reach is the watchdog boundary. The block has to sit in the active state with no acknowledgement until exactly the 128th tick, and the lapse must not be confused with a normal power-off. The bench runs one sequence with both acknowledge inputs held low. A behavioural model follows every tick on every clock, so the timeout cycle and the power-down that follows are compared exactly.

The bench also drives requests at moments where they must be ignored: a start during power-up and during power-down, a power-off during power-up, and delay changes during a sequence. It uses the delay extremes 0 and 63, which check the first and last cycles of both the rising and the falling order.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    SQ_STBY = 2'd0,
    SQ_RISE = 2'd1,
    SQ_ON   = 2'd2,
    SQ_FALL = 2'd3
  } sq_state_t;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (adv && (cnt != TOP));
    cnt_d  = clr ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  AST_TMR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && adv && !clr) |=> (cnt == TOP)); // R7
  AST_TMR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R2
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int N     = 5,
  parameter int DLY_W = 6,
  parameter int CNT_W = 7,
  parameter int WD_MS = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start_req,
  input  logic               ack_pin,
  input  logic               ack_reg,
  input  logic               off_req,
  input  logic [N*DLY_W-1:0] cfg_in,
  input  logic [CNT_W-1:0]   cnt,
  output sq_state_t          st_q,
  output logic [N*DLY_W-1:0] cfg_q,
  output logic               tmr_clr,
  output logic               tmr_adv
);
  localparam logic [CNT_W-1:0] SPAN    = CNT_W'((1 << DLY_W) - 1);
  localparam logic [CNT_W-1:0] WD_LAST = CNT_W'(WD_MS - 1);

  sq_state_t st_d;
  logic      acked_q, acked_d;
  logic      cfg_en;
  logic      ack_any;

  assign ack_any = acked_q | ack_pin | ack_reg;

  always_comb begin
    st_d    = st_q;
    acked_d = acked_q;
    cfg_en  = 1'b0;
    tmr_clr = 1'b0;
    case (st_q)
      SQ_STBY: begin
        if (start_req) begin
          st_d    = SQ_RISE;
          tmr_clr = 1'b1;
          cfg_en  = 1'b1;
          acked_d = 1'b0;
        end
      end
      SQ_RISE: begin
        if (ack_any) acked_d = 1'b1;
        if (cnt == SPAN) st_d = SQ_ON;
      end
      SQ_ON: begin
        if (off_req) begin
          st_d    = SQ_FALL;
          tmr_clr = 1'b1;
        end else if (!ack_any && tick && (cnt == WD_LAST)) begin
          st_d    = SQ_FALL;
          tmr_clr = 1'b1;
        end else if (ack_any) begin
          acked_d = 1'b1;
        end
      end
      SQ_FALL: begin
        if (cnt == SPAN) begin
          st_d    = SQ_STBY;
          tmr_clr = 1'b1;
        end
      end
      default: st_d = SQ_STBY;
    endcase
    tmr_adv = tick && (st_q != SQ_STBY) && !tmr_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_STBY;
      acked_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      acked_q <= acked_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_in;
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_FALL) |=> (st_q != SQ_RISE)); // R8
  AST_WD_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ON && !acked_q && !ack_pin && !ack_reg && tick && cnt == WD_LAST)
      |=> (st_q == SQ_FALL)); // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ON && ack_any && !off_req) |=> (st_q == SQ_ON)); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_STBY) |=> $stable(cfg_q)); // R9
  AST_OFF_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RISE && cnt != SPAN) |=> (st_q == SQ_RISE)); // R10
endmodule

// File: rtl/pwr_seq_rail.sv
module pwr_seq_rail
  import pwr_seq_pkg::*;
#(
  parameter int DLY_W = 6,
  parameter int CNT_W = 7
) (
  input  sq_state_t        st,
  input  logic [CNT_W-1:0] cnt,
  input  logic [DLY_W-1:0] dly,
  output logic             en
);
  logic [DLY_W-1:0] off_dly;
  logic             rise_hit;
  logic             fall_keep;

  always_comb begin
    off_dly   = ~dly;
    rise_hit  = cnt >= CNT_W'(dly);
    fall_keep = cnt < CNT_W'(off_dly);
    case (st)
      SQ_RISE, SQ_ON: en = rise_hit;
      SQ_FALL:        en = fall_keep;
      default:        en = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_RAILS = 5,
  parameter int DLY_W     = 6,
  parameter int WD_MS     = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_1ms,
  input  logic                       pwr_on_req,
  input  logic                       ack_pin,
  input  logic                       ack_reg_bit,
  input  logic                       pwr_off_req,
  input  logic [NUM_RAILS*DLY_W-1:0] dly_cfg,
  output logic [NUM_RAILS-1:0]       rail_en,
  output logic                       busy,
  output logic                       active
);
  localparam int CNT_W = $clog2(WD_MS);

  logic [1:0]                 rst_sync;
  logic                       rst_core_n;
  sq_state_t                  st;
  logic [NUM_RAILS*DLY_W-1:0] cfg_q;
  logic [CNT_W-1:0]           cnt;
  logic                       tmr_clr;
  logic                       tmr_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  pwr_seq_ctrl #(
    .N(NUM_RAILS), .DLY_W(DLY_W), .CNT_W(CNT_W), .WD_MS(WD_MS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .tick(tick_1ms),
    .start_req(pwr_on_req), .ack_pin(ack_pin), .ack_reg(ack_reg_bit),
    .off_req(pwr_off_req), .cfg_in(dly_cfg), .cnt(cnt),
    .st_q(st), .cfg_q(cfg_q), .tmr_clr(tmr_clr), .tmr_adv(tmr_adv)
  );

  pwr_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_core_n), .clr(tmr_clr), .adv(tmr_adv), .cnt(cnt)
  );

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    pwr_seq_rail #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_rail (
      .st(st), .cnt(cnt), .dly(cfg_q[i*DLY_W +: DLY_W]), .en(rail_en[i])
    );

    AST_RISE_KEEP: assert property (@(posedge clk) disable iff (!rst_core_n)
      (st == SQ_RISE && rail_en[i]) |=> rail_en[i]); // R3
    AST_FALL_NO_RELIGHT: assert property (@(posedge clk) disable iff (!rst_core_n)
      (st == SQ_FALL && !rail_en[i]) |=> !rail_en[i]); // R5
  end

  assign busy   = (st == SQ_RISE) || (st == SQ_FALL);
  assign active = (st == SQ_ON);

  AST_STBY_DARK: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st == SQ_STBY) |-> (rail_en == '0)); // R1
  AST_ON_FULL: assert property (@(posedge clk) disable iff (!rst_core_n)
    active |-> (&rail_en)); // R4
endmodule

// File: tb/sim_pwr_rail_seq.sv
module sim_pwr_rail_seq;
  localparam int N  = 5;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          on_req = 1'b0;
  logic          ack_p = 1'b0;
  logic          ack_r = 1'b0;
  logic          off_req = 1'b0;
  logic [N*DW-1:0] cfg = '0;
  logic [N-1:0]  en;
  logic          busy, active;

  always #5 clk = ~clk;

  pwr_rail_seq #(.NUM_RAILS(N), .DLY_W(DW), .WD_MS(128)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .pwr_on_req(on_req),
    .ack_pin(ack_p), .ack_reg_bit(ack_r), .pwr_off_req(off_req),
    .dly_cfg(cfg), .rail_en(en), .busy(busy), .active(active)
  );

  int    tests = 0;
  int    fails = 0;
  string tag = "R1";
  bit    tick_run = 1'b0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  int    ph = 0;

  int m_st = 0;
  int m_cnt = 0;
  int m_acked = 0;
  int m_cfg [N];

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (tick_run) begin
      ph = (ph + 1) % 4;
      tick = (ph == 0);
    end else begin
      tick = 1'b0;
    end
  end

  // Behavioural reference: 0 standby, 1 rising, 2 on, 3 falling
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_acked = 0;
      for (int i = 0; i < N; i++) m_cfg[i] = 0;
    end else begin
      case (m_st)
        0: if (on_req) begin
             m_st = 1; m_cnt = 0; m_acked = 0;
             for (int i = 0; i < N; i++) m_cfg[i] = int'(cfg[i*DW +: DW]);
           end
        1: begin
             if (ack_p || ack_r) m_acked = 1;
             if (m_cnt == 63) m_st = 2;
             if (tick) m_cnt++;
           end
        2: begin
             if (off_req) begin
               m_st = 3; m_cnt = 0;
             end else if (!(m_acked == 1 || ack_p || ack_r) && tick && m_cnt == 127) begin
               m_st = 3; m_cnt = 0;
             end else begin
               if (ack_p || ack_r) m_acked = 1;
               if (tick && m_cnt < 127) m_cnt++;
             end
           end
        default: begin
             if (m_cnt == 63) begin
               m_st = 0; m_cnt = 0;
             end else if (tick) m_cnt++;
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int exp_en;
      exp_en = 0;
      for (int i = 0; i < N; i++) begin
        if ((m_st == 1 || m_st == 2) && m_cnt >= m_cfg[i]) exp_en |= (1 << i);
        if (m_st == 3 && m_cnt < 63 - m_cfg[i]) exp_en |= (1 << i);
      end
      chk(tag, "rail_en", int'(en), exp_en);
      chk(tag, "busy", int'(busy), (m_st == 1 || m_st == 3) ? 1 : 0);
      chk(tag, "active", int'(active), (m_st == 2) ? 1 : 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_on();
    @(negedge clk); on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
  endtask

  task automatic pulse_off();
    @(negedge clk); off_req = 1'b1;
    @(negedge clk); off_req = 1'b0;
  endtask

  task automatic wait_active();
    for (int k = 0; k < 3000 && !active; k++) @(negedge clk);
  endtask

  task automatic wait_standby();
    for (int k = 0; k < 3000 && (busy || active); k++) @(negedge clk);
  endtask

  function automatic logic [N*DW-1:0] pack(int d0, int d1, int d2, int d3, int d4);
    return {DW'(d4), DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
  endfunction

  initial begin
    #(10 * 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cfg = pack(3, 5, 15, 20, 25);
    cyc(3);
    chk("R1", "rail_en in reset", int'(en), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "active in reset", int'(active), 0);
    rst_n = 1'b1;
    cyc(5);
    cmp_on = 1'b1;
    tick_run = 1'b1;
    cyc(8);
    chk("R1", "rail_en idle", int'(en), 0);

    // default delays, pin acknowledge
    tag = "R2";
    pulse_on();
    chk("R2", "busy after start", int'(busy), 1);
    tag = "R3";
    cyc(20);
    ack_p = 1'b1; cyc(4); ack_p = 1'b0;
    wait_active();
    tag = "R4";
    chk("R4", "all on", int'(en), 31);
    tag = "R6";
    cyc(700);
    chk("R6", "still active after pin ack", int'(active), 1);
    tag = "R5";
    pulse_off();
    chk("R5", "busy in power-down", int'(busy), 1);
    wait_standby();
    cyc(2);
    chk("R5", "all off after power-down", int'(en), 0);

    // delay extremes, config change, ignored requests, register ack
    cfg = pack(0, 63, 10, 10, 40);
    tag = "R9";
    pulse_on();
    chk("R3", "zero delay on at once", int'(en[0]), 1);
    cfg = pack(1, 1, 1, 1, 1);
    tag = "R10";
    cyc(6);
    pulse_off();
    cyc(2);
    chk("R10", "off ignored while rising", int'(busy), 1);
    tag = "R8";
    cyc(10);
    pulse_on();
    tag = "R6";
    cyc(30);
    ack_r = 1'b1; cyc(1); ack_r = 1'b0;
    wait_active();
    chk("R4", "all on with extremes", int'(en), 31);
    cyc(700);
    chk("R6", "still active after register ack", int'(active), 1);
    tag = "R5";
    pulse_off();
    chk("R5", "delay 63 group off at once", int'(en[1]), 0);
    cyc(40);
    tag = "R8";
    pulse_on();
    wait_standby();
    cyc(6);
    chk("R8", "start during power-down ignored", int'(busy), 0);
    chk("R8", "stays dark", int'(en), 0);
    tag = "R10";
    pulse_off();
    cyc(4);
    chk("R10", "off ignored in standby", int'(busy), 0);

    // no acknowledge: watchdog lapse
    cfg = pack(3, 5, 15, 20, 25);
    tag = "R7";
    pulse_on();
    wait_active();
    for (int k = 0; k < 3000 && active; k++) @(negedge clk);
    chk("R7", "power-down after lapse", int'(busy), 1);
    chk("R7", "not active after lapse", int'(active), 0);
    wait_standby();
    cyc(2);
    chk("R7", "dark after lapse", int'(en), 0);

    cyc(4);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule